// File: doc/BRIEF.md
# PWM Timebase with Double-Buffered Period

This block is the time reference for a PWM channel. A free-running up-counter advances on ticks from a programmable prescaler and wraps back to zero after it reaches the active period. When it wraps it raises a one-cycle zero pulse. When it lands on the active period it raises a one-cycle period-match pulse. Later compare stages use this count and these pulses to build output waveforms.

Software does not change the active period directly. A 32-bit configuration write holds a prescale divisor, a shadow period and a 2-bit load policy. The policy sets when the shadow value enters the active period: at once, at the next wrap to zero, at the next sync pulse, or at whichever of those two comes first. A sync pulse also forces the counter back to zero. This lets several timebases be phase-aligned.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000FF00 (prescale 0, shadow period 255, policy 0). The active period is 255, the counter is 0 and both pulses are low.
- R2: Bits 7:0 of the configuration word give the prescale value P. The counter advances once every P+1 cycles in which `pwm_en` is high. Cycles with `pwm_en` low neither advance the counter nor the prescaler.
- R3: Every configuration write restarts the prescaler count from zero. The next tick then comes P+1 enabled cycles after the write.
- R4: On a tick, the counter increments. If the count is already greater than or equal to the active period, it loads 0 instead, and `tez_pulse` is high for the one cycle after that wrap.
- R5: `tep_pulse` is high for one cycle whenever an update leaves the counter equal to the active period.
- R6: Bits 23:8 hold the shadow period and bits 25:24 hold the load policy. When a write carries policy 0, its period becomes active at the same clock edge.
- R7: With policy 1, a write arms a pending load. The shadow period becomes active at the next wrap to zero, and the pending state is then cleared. A second write before that wrap replaces the shadow value. Without a pending load the active period never changes.
- R8: With policy 2, the pending load happens on the next `sync_in` cycle. `sync_in` always sets the counter to 0 on the next edge, whether or not `pwm_en` is high, and it does not raise `tez_pulse`.
- R9: With policy 3, the pending load happens on the first wrap or sync. When a sync and a wrap tick fall in the same cycle, the sync wins, so exactly one load takes place.
- R10: Bits 31:26 of the configuration word read back as 0, whatever was written to them.
- R11: When a configuration write falls in the same cycle as a load event, the old shadow value is loaded. The newly written value is stored and left pending (or, under policy 0, made active at once).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_en | input | 1 | Clock enable that feeds the prescaler |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: prescale 7:0, shadow period 23:8, policy 25:24 |
| sync_in | input | 1 | Sync pulse: clears the counter and can trigger a period load |
| cfg_rdata | output | 32 | Configuration word readback |
| cnt_val | output | 16 | Current timer count |
| tez_pulse | output | 1 | One-cycle pulse after a wrap to zero |
| tep_pulse | output | 1 | One-cycle pulse when the count equals the active period |

## Verification
Two pairs of events can land in the same cycle. The first is a sync pulse together with a wrap tick. The second is a configuration write together with a pending load event. The bench provokes both by reading its own reference model at the falling edge. When the model shows that the coming edge will wrap the counter, the bench drives `sync_in` or a new configuration word into exactly that cycle. It judges the outcome by comparing the count, both pulses and the readback against the model on every clock. Any double load or lost shadow value then shows up as a wrong wrap point later on.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    LOAD_NOW    = 2'd0,
    LOAD_ZERO   = 2'd1,
    LOAD_SYNC   = 2'd2,
    LOAD_EITHER = 2'd3
  } load_mode_t;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] pc_q;

  assign tick = en && (pc_q == presc);

  always_ff @(posedge clk) begin
    if (rst || restart) pc_q <= '0;
    else if (en)        pc_q <= tick ? '0 : pc_q + PRESC_W'(1);
  end

  AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> pc_q == '0); // R3
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    pc_q <= presc); // R2
  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable(pc_q)); // R2
endmodule

// File: rtl/pwm_tb_period_buf.sv
module pwm_tb_period_buf
  import pwm_timebase_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [PER_W-1:0] wr_period,
  input  load_mode_t       wr_mode,
  input  logic             zero_evt,
  input  logic             sync_evt,
  output load_mode_t       mode_q,
  output logic [PER_W-1:0] shadow_q,
  output logic [PER_W-1:0] act_q,
  output logic [PER_W-1:0] act_d
);
  logic pend_q;
  logic xfer;

  assign xfer = pend_q && ((mode_q[0] && zero_evt) || (mode_q[1] && sync_evt));

  always_comb begin
    act_d = act_q;
    if (xfer) act_d = shadow_q;
    if (wr && wr_mode == LOAD_NOW) act_d = wr_period;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= LOAD_NOW;
      shadow_q <= PER_W'(RST_PERIOD);
      act_q    <= PER_W'(RST_PERIOD);
      pend_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      if (wr) begin
        mode_q   <= wr_mode;
        shadow_q <= wr_period;
        pend_q   <= (wr_mode != LOAD_NOW);
      end else if (xfer) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_mode == LOAD_NOW) |=> act_q == $past(wr_period)); // R6
  AST_PEND_ARM: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_mode != LOAD_NOW) |=> pend_q); // R7
  AST_ACT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !wr) |=> act_q == $past(act_q)); // R7
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sync,
  input  logic [PER_W-1:0] act_q,
  input  logic [PER_W-1:0] act_d,
  output logic             zero_evt,
  output logic [PER_W-1:0] cnt_q,
  output logic             tez_q,
  output logic             tep_q
);
  logic             wrap;
  logic             upd;
  logic [PER_W-1:0] cnt_d;

  always_comb begin
    wrap     = (cnt_q >= act_q);
    zero_evt = tick && !sync && wrap;
    upd      = sync || tick;
    if (sync)      cnt_d = '0;
    else if (tick) cnt_d = wrap ? '0 : cnt_q + PER_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tez_q <= 1'b0;
      tep_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tez_q <= zero_evt;
      tep_q <= upd && (cnt_d == act_d);
    end
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync |=> cnt_q == '0); // R8
  AST_TEZ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    tez_q |-> cnt_q == '0); // R4
  AST_TEP_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tep_q |-> cnt_q == act_q); // R5
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sync) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int PRESC_W    = 8,
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_en,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  logic             sync_in,
  output logic [31:0]      cfg_rdata,
  output logic [PER_W-1:0] cnt_val,
  output logic             tez_pulse,
  output logic             tep_pulse
);
  localparam int PER_LSB  = PRESC_W;
  localparam int MODE_LSB = PRESC_W + PER_W;
  localparam int USED_W   = MODE_LSB + 2;
  localparam logic [31:0] RD_MASK = 32'((64'd1 << USED_W) - 64'd1);

  logic [PRESC_W-1:0] presc_q;
  logic               tick;
  logic               zero_evt;
  load_mode_t         mode_q;
  logic [PER_W-1:0]   shadow_q;
  logic [PER_W-1:0]   act_q;
  logic [PER_W-1:0]   act_d;

  always_ff @(posedge clk) begin
    if (rst)         presc_q <= '0;
    else if (cfg_wr) presc_q <= cfg_wdata[PRESC_W-1:0];
  end

  pwm_tb_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .en(pwm_en), .restart(cfg_wr),
    .presc(presc_q), .tick(tick)
  );

  pwm_tb_period_buf #(.PER_W(PER_W), .RST_PERIOD(RST_PERIOD)) u_pbuf (
    .clk(clk), .rst(rst), .wr(cfg_wr),
    .wr_period(cfg_wdata[MODE_LSB-1:PER_LSB]),
    .wr_mode(load_mode_t'(cfg_wdata[USED_W-1:MODE_LSB])),
    .zero_evt(zero_evt), .sync_evt(sync_in),
    .mode_q(mode_q), .shadow_q(shadow_q), .act_q(act_q), .act_d(act_d)
  );

  pwm_tb_counter #(.PER_W(PER_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .sync(sync_in),
    .act_q(act_q), .act_d(act_d), .zero_evt(zero_evt),
    .cnt_q(cnt_val), .tez_q(tez_pulse), .tep_q(tep_pulse)
  );

  assign cfg_rdata = {{(32-USED_W){1'b0}}, mode_q, shadow_q, presc_q};

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & RD_MASK)); // R10
  AST_SYNC_NO_TEZ: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> !tez_pulse); // R8
endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sync_in = 1'b0;
  logic [31:0] cfg_rdata;
  logic [15:0] cnt_val;
  logic        tez_pulse;
  logic        tep_pulse;

  always #5 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .sync_in(sync_in), .cfg_rdata(cfg_rdata),
    .cnt_val(cnt_val), .tez_pulse(tez_pulse), .tep_pulse(tep_pulse)
  );

  int    nchk = 0;
  int    nfail = 0;
  string phase_req = "R1";

  // behavioural reference state
  int unsigned m_cfg, m_act, m_pc, m_cnt;
  bit          m_pend, m_tez, m_tep;

  function automatic logic [31:0] mk(int mode, int per, int presc);
    return {6'b0, 2'(mode), 16'(per), 8'(presc)};
  endfunction

  task automatic chk(string req, string what, bit ok, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    int unsigned presc, mode, shadow, ncnt, nact;
    bit tick, zero, xfer;
    if (rst) begin
      m_cfg = 32'h0000FF00; m_act = 255; m_pc = 0; m_cnt = 0;
      m_pend = 0; m_tez = 0; m_tep = 0;
    end else begin
      presc  = m_cfg & 32'hFF;
      shadow = (m_cfg >> 8) & 32'hFFFF;
      mode   = (m_cfg >> 24) & 3;
      tick   = pwm_en && (m_pc == presc);
      zero   = tick && !sync_in && (m_cnt >= m_act);
      xfer   = m_pend && ((mode[0] && zero) || (mode[1] && sync_in));
      nact   = m_act;
      if (xfer) begin nact = shadow; m_pend = 0; end
      if (cfg_wr) begin
        m_cfg = cfg_wdata & 32'h03FFFFFF;
        if (cfg_wdata[25:24] == 2'd0) begin nact = cfg_wdata[23:8]; m_pend = 0; end
        else m_pend = 1;
      end
      if (cfg_wr)      m_pc = 0;
      else if (pwm_en) m_pc = tick ? 0 : m_pc + 1;
      if (sync_in)   ncnt = 0;
      else if (tick) ncnt = (m_cnt >= m_act) ? 0 : m_cnt + 1;
      else           ncnt = m_cnt;
      m_tez = zero;
      m_tep = (sync_in || tick) && (ncnt == nact);
      m_cnt = ncnt;
      m_act = nact;
    end
    #2;
    chk(phase_req, "count", cnt_val == 16'(m_cnt), cnt_val, m_cnt);
    chk(phase_req, "zero pulse", tez_pulse == m_tez, tez_pulse, m_tez);
    chk(phase_req, "period pulse", tep_pulse == m_tep, tep_pulse, m_tep);
    chk("R10", "readback", cfg_rdata == m_cfg, cfg_rdata, m_cfg);
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic step(bit wr, logic [31:0] d, bit sy, bit en);
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = d; sync_in = sy; pwm_en = en;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 1);
  endtask

  // drive wr/sync into the cycle whose edge makes the counter wrap
  task automatic at_wrap(bit wr, logic [31:0] d, bit sy);
    forever begin
      @(negedge clk);
      if (pwm_en && m_pc == (m_cfg & 32'hFF) && m_cnt >= m_act) begin
        cfg_wr = wr; cfg_wdata = d; sync_in = sy;
        break;
      end
      cfg_wr = 0; sync_in = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase_req = "R1";
    chk("R1", "reset readback", cfg_rdata == 32'h0000FF00, cfg_rdata, 32'h0000FF00);
    chk("R1", "reset count", cnt_val == 0, cnt_val, 0);

    phase_req = "R4";                       // default period 255, wraps
    idle(600);
    phase_req = "R5";
    idle(300);

    phase_req = "R6";                       // immediate load, prescale 2
    step(1, mk(0, 10, 2), 0, 1);
    idle(80);
    phase_req = "R2";                       // gaps in the enable
    for (int i = 0; i < 60; i++) step(0, '0, 0, (i % 3) != 1);
    phase_req = "R3";                       // writes restart the prescaler
    step(1, mk(0, 10, 4), 0, 1);
    idle(3);
    step(1, mk(0, 10, 4), 0, 1);
    idle(40);

    phase_req = "R7";                       // policy 1, overwritten shadow
    step(1, mk(0, 12, 0), 0, 1);
    idle(5);
    step(1, mk(1, 20, 0), 0, 1);
    idle(2);
    step(1, mk(1, 30, 0), 0, 1);
    idle(80);

    phase_req = "R8";                       // policy 2, sync load
    step(1, mk(2, 5, 0), 0, 1);
    idle(40);
    step(0, '0, 1, 0);
    idle(30);
    step(0, '0, 1, 1);
    idle(20);

    phase_req = "R9";                       // policy 3, sync on wrap edge
    step(1, mk(0, 9, 0), 0, 1);
    idle(3);
    step(1, mk(3, 7, 0), 0, 1);
    at_wrap(0, '0, 1);
    idle(40);
    step(1, mk(3, 4, 1), 0, 1);
    idle(40);

    phase_req = "R11";                      // write on the load edge
    step(1, mk(1, 6, 0), 0, 1);
    at_wrap(1, mk(1, 15, 0), 0);
    idle(60);
    step(1, mk(1, 3, 0), 0, 1);
    at_wrap(1, mk(0, 8, 0), 0);
    idle(30);

    phase_req = "R10";                      // reserved bits
    step(1, 32'hFFFF_0203, 0, 1);
    step(0, '0, 0, 1);
    chk("R10", "reserved bits", cfg_rdata == 32'h03FF_0203, cfg_rdata, 32'h03FF_0203);
    idle(20);

    phase_req = "R9";                       // random mix, short periods
    step(1, mk(0, 6, 0), 0, 1);
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom % 23) == 0;
      step(w, mk($urandom % 4, $urandom % 12, $urandom % 3),
           ($urandom % 17) == 0, ($urandom % 5) != 0);
    end
    idle(20);
    finish_run();
  end
endmodule